// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Detector with Input Filter

This block turns a bank of general-purpose input lines into interrupt requests. Software sets up each line through a small write port. A line can sense a level or an edge, and it can be active-high/rising or active-low/falling. Each line can be enabled and masked, and each line can optionally pass through a glitch filter first. The filter samples on a slow tick, so it needs no second clock tree. Edge events are held in sticky latches until software writes ones to the end-of-interrupt selector. The block reports a raw pending vector and a qualified pending vector, and drives one combined interrupt line.

Every control and status pin is plain. There is no streaming data path here, so there is no valid/ready handshake and no back-pressure. A write strobe is taken on every clock edge where it is high. The line inputs are assumed to be synchronous to `clk` already. Both-edge sensing is not built in: software flips the polarity bit after each serviced edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every enable, mask, sense-type, polarity and filter bit is 0, every edge latch is clear, and `irq_o` and `status_o` are 0.
- R2: When the sense-type bit of a line is 0 (level), `raw_o[n]` equals the line's qualified input if polarity is 1, and its inverse if polarity is 0. It follows the input in the same cycle.
- R3: When the sense-type bit is 1 (edge), a selected edge sets `raw_o[n]`, and it stays set after the input returns. Polarity 1 selects a 0-to-1 change and polarity 0 selects a 1-to-0 change. The edge is seen between the qualified values of two consecutive cycles.
- R4: A write with `wr_sel` = 5 (end-of-interrupt) clears every edge latch whose `wr_data` bit is 1. Latches whose bit is 0 are left unchanged.
- R5: If a selected edge and an end-of-interrupt clear for the same line fall on the same clock edge, the latch ends up set.
- R6: `status_o` = `raw_o` AND enable AND NOT mask, bit by bit. Enable is `wr_sel` = 0 and mask is `wr_sel` = 1. Masking and enabling are independent.
- R7: `irq_o` is the OR of `status_o` registered once: it shows the value that `status_o` had one cycle earlier.
- R8: For a line whose filter bit (`wr_sel` = 4) is 1, the qualified input changes only on a cycle where `db_tick` is high. It takes the pin value only when that value matches the pin value sampled at the previous tick.
- R9: For a line whose filter bit is 0, the qualified input is the pin value itself, with no delay.
- R10: A write with `wr_sel` = 0, 1, 2, 3 or 4 loads the whole `wr_data` vector into enable, mask, sense-type, polarity or filter select respectively. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_tick | input | 1 | Slow sampling enable for the input filter |
| line_in | input | N_LINES | Input pins, synchronous to clk |
| wr_stb | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target: 0 enable, 1 mask, 2 type, 3 polarity, 4 filter, 5 end-of-interrupt |
| wr_data | input | N_LINES | Write value, one bit per line |
| raw_o | output | N_LINES | Pending before enable and mask |
| status_o | output | N_LINES | Pending after enable and mask |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The timing of each result is counted from a clock edge. Level-sensed raw and qualified status follow an unfiltered pin in the same cycle. Edge latches, configuration writes and clears take effect on the clock edge that samples them. `irq_o` comes one edge after the status it summarizes, and a filtered line moves on the second matching tick. The bench drives inputs just after a rising edge, samples outputs mid-cycle, and then advances a reference model through the same edge. The model mirrors that latency, so every comparison lands in the cycle where the result is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_TYPE   = 3'd2,
    SEL_POL    = 3'd3,
    SEL_FILT   = 3'd4,
    SEL_EOI    = 3'd5
  } reg_sel_e;

  localparam int SEL_W = $bits(reg_sel_e);

  // Selected transition between previous and current sample.
  function automatic logic edge_seen(input logic pol, input logic cur, input logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Level match: active-high when pol is 1, active-low otherwise.
  function automatic logic level_seen(input logic pol, input logic cur);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] en_q,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] type_q,
  output logic [N_LINES-1:0] pol_q,
  output logic [N_LINES-1:0] filt_q,
  output logic [N_LINES-1:0] eoi_clr
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      filt_q <= '0;
    end else if (wr_stb) begin
      case (sel)
        SEL_ENABLE: en_q   <= wr_data;
        SEL_MASK:   mask_q <= wr_data;
        SEL_TYPE:   type_q <= wr_data;
        SEL_POL:    pol_q  <= wr_data;
        SEL_FILT:   filt_q <= wr_data;
        default: ;
      endcase
    end
  end

  // End-of-interrupt is a pulse, not a stored register.
  assign eoi_clr = (wr_stb && sel == SEL_EOI) ? wr_data : '0;

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_LINES-1:0] pin,
  output logic [N_LINES-1:0] clean
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic last_smp;
    logic held;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_smp <= 1'b0;
        held     <= 1'b0;
      end else if (tick) begin
        last_smp <= pin[i];
        if (pin[i] == last_smp) held <= pin[i];
      end
    end

    assign clean[i] = held;
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] qual,
  input  logic [N_LINES-1:0] type_q,
  input  logic [N_LINES-1:0] pol_q,
  input  logic [N_LINES-1:0] eoi_clr,
  output logic [N_LINES-1:0] latch_q,
  output logic [N_LINES-1:0] raw
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic prev_q;
    logic hit;

    assign hit = type_q[i] & edge_seen(pol_q[i], qual[i], prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q     <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        prev_q     <= qual[i];
        // set has priority over clear; latch dropped in level mode
        latch_q[i] <= ((latch_q[i] & ~eoi_clr[i]) | hit) & type_q[i];
      end
    end

    assign raw[i] = type_q[i] ? latch_q[i] : level_seen(pol_q[i], qual[i]);
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               db_tick,
  input  logic [N_LINES-1:0] line_in,
  input  logic               wr_stb,
  input  logic [2:0]         wr_sel,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] raw_o,
  output logic [N_LINES-1:0] status_o,
  output logic               irq_o
);

  logic [N_LINES-1:0] cfg_en, cfg_mask, cfg_type, cfg_pol, cfg_filt, eoi_clr;
  logic [N_LINES-1:0] filt_out, qual, edge_latch;

  gpio_irq_cfg #(.N_LINES(N_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_q(cfg_en), .mask_q(cfg_mask), .type_q(cfg_type), .pol_q(cfg_pol),
    .filt_q(cfg_filt), .eoi_clr(eoi_clr)
  );

  gpio_irq_filter #(.N_LINES(N_LINES)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(db_tick), .pin(line_in), .clean(filt_out)
  );

  assign qual = (cfg_filt & filt_out) | (~cfg_filt & line_in);

  gpio_irq_sense #(.N_LINES(N_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .qual(qual), .type_q(cfg_type), .pol_q(cfg_pol),
    .eoi_clr(eoi_clr), .latch_q(edge_latch), .raw(raw_o)
  );

  assign status_o = raw_o & cfg_en & ~cfg_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |status_o;
  end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               db_tick,
  input logic               wr_stb,
  input logic [2:0]         wr_sel,
  input logic [N_LINES-1:0] wr_data,
  input logic [N_LINES-1:0] raw_o,
  input logic [N_LINES-1:0] status_o,
  input logic               irq_o,
  input logic [N_LINES-1:0] cfg_en,
  input logic [N_LINES-1:0] cfg_mask,
  input logic [N_LINES-1:0] cfg_type,
  input logic [N_LINES-1:0] cfg_pol,
  input logic [N_LINES-1:0] cfg_filt,
  input logic [N_LINES-1:0] qual,
  input logic [N_LINES-1:0] edge_latch
);

  logic [N_LINES-1:0] prev_seen;
  logic [N_LINES-1:0] hit_w;
  logic [N_LINES-1:0] clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_seen <= '0;
    else        prev_seen <= qual;
  end

  assign hit_w = cfg_type & ((cfg_pol & qual & ~prev_seen) | (~cfg_pol & ~qual & prev_seen));
  assign clr_w = (wr_stb && wr_sel == 3'd5) ? wr_data : '0;

  AST_IRQ_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|status_o))); // R7

  AST_STATUS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~(raw_o & cfg_en)) == '0); // R6

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (~cfg_type & (raw_o ^ ~(qual ^ cfg_pol))) == '0); // R2

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit_w) & ~edge_latch) == '0)); // R5

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_w) & ~$past(hit_w) & edge_latch) == '0)); // R4

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_latch) & $past(cfg_type) & cfg_type & ~$past(clr_w) & ~edge_latch) == '0)); // R3

  AST_FILTER_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(db_tick) || ((cfg_filt & $past(cfg_filt) & (qual ^ $past(qual))) == '0))); // R8

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_tick(db_tick), .wr_stb(wr_stb), .wr_sel(wr_sel),
  .wr_data(wr_data), .raw_o(raw_o), .status_o(status_o), .irq_o(irq_o),
  .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_type(cfg_type), .cfg_pol(cfg_pol),
  .cfg_filt(cfg_filt), .qual(qual), .edge_latch(edge_latch)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic db_tick = 1'b0;
  logic [N-1:0] line_in = '0;
  logic wr_stb = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] raw_o, status_o;
  logic irq_o;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [N-1:0] m_en, m_mask, m_type, m_pol, m_filt, m_latch, m_held, m_last, m_prev;
  logic m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.N_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .db_tick(db_tick), .line_in(line_in),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .raw_o(raw_o), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [N-1:0] m_qual();
    return (m_filt & m_held) | (~m_filt & line_in);
  endfunction

  function automatic logic [N-1:0] m_raw();
    logic [N-1:0] q = m_qual();
    return (m_type & m_latch) | (~m_type & ~(q ^ m_pol));
  endfunction

  task automatic cmp(input string tag, input string what, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // sample mid-cycle, then advance model and DUT through one edge
  task automatic run(input string tag);
    logic [N-1:0] q, hit, clr, st, diff;
    #1;
    cmp(tag, "raw", raw_o, m_raw());
    st = m_raw() & m_en & ~m_mask;
    cmp(tag, "status", status_o, st);
    cmp(tag, "irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
    q = m_qual();
    hit = m_type & ((m_pol & q & ~m_prev) | (~m_pol & ~q & m_prev));
    clr = (wr_stb && wr_sel == 3'd5) ? wr_data : '0;
    @(posedge clk);
    #1;
    m_latch = ((m_latch & ~clr) | hit) & m_type;
    m_prev = q;
    m_irq = |st;
    if (db_tick) begin
      diff = line_in ^ m_last;
      m_held = (~diff & line_in) | (diff & m_held);
      m_last = line_in;
    end
    if (wr_stb) begin
      case (wr_sel)
        3'd0: m_en = wr_data;
        3'd1: m_mask = wr_data;
        3'd2: m_type = wr_data;
        3'd3: m_pol = wr_data;
        3'd4: m_filt = wr_data;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] d, input string tag);
    wr_stb = 1'b1; wr_sel = sel; wr_data = d;
    run(tag);
    wr_stb = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_en = '0; m_mask = '0; m_type = '0; m_pol = '0; m_filt = '0;
    m_latch = '0; m_held = '0; m_last = '0; m_prev = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, zero config, nothing pending
    run("R1");
    cmp("R1", "status", status_o, '0);

    // R10 / R2 / R6: full level sweep over polarity and inputs
    wr(3'd0, '1, "R10");
    for (int p = 0; p < 16; p++) begin
      wr(3'd3, N'(p), "R10");
      for (int v = 0; v < 16; v++) begin
        line_in = N'(v);
        run("R2");
      end
    end

    // R6: enable x mask sweep, R7 irq checked along the way
    wr(3'd3, '1, "R10");
    line_in = 4'b1011;
    for (int e = 0; e < 16; e++) begin
      wr(3'd0, N'(e), "R6");
      for (int k = 0; k < 16; k++) begin
        wr(3'd1, N'(k), "R6");
        run("R7");
      end
    end
    wr(3'd1, '0, "R6");
    wr(3'd0, '1, "R6");

    // R3: edge mode, each polarity, walking input patterns
    line_in = '0;
    wr(3'd2, '1, "R3");
    for (int p = 0; p < 16; p++) begin
      wr(3'd3, N'(p), "R3");
      wr(3'd5, '1, "R4");
      for (int s = 0; s < 12; s++) begin
        line_in = N'((s * 5 + p) % 16);
        run("R3");
      end
    end

    // R4: partial end-of-interrupt clears
    wr(3'd3, '1, "R4");
    for (int d = 0; d < 16; d++) begin
      line_in = '0; run("R4");
      line_in = '1; run("R3");
      line_in = '0; run("R3");
      wr(3'd5, N'(d), "R4");
      run("R4");
      wr(3'd5, '1, "R4");
    end

    // R5: edge and clear on the same edge, both polarities
    for (int p = 0; p < 2; p++) begin
      wr(3'd3, p ? '1 : '0, "R5");
      line_in = p ? '0 : '1; run("R5");
      wr(3'd5, '1, "R5");
      line_in = ~line_in;
      wr(3'd5, '1, "R5");
      run("R5");
    end

    // R8: all lines filtered, level active-high, ticks every third cycle
    wr(3'd5, '1, "R4");
    wr(3'd2, '0, "R8");
    wr(3'd3, '1, "R8");
    wr(3'd4, '1, "R8");
    for (int c = 0; c < 120; c++) begin
      db_tick = (c % 3 == 0);
      line_in = ((c / 4) % 3 == 0) ? N'((c * 7) % 16) : N'((c / 9) % 16);
      run("R8");
    end

    // R9: mixed filtered and bypassed lines, edge mode
    wr(3'd4, 4'b0101, "R9");
    wr(3'd2, 4'b0011, "R9");
    for (int c = 0; c < 80; c++) begin
      db_tick = (c % 2 == 0);
      line_in = N'((c * 11 + c / 5) % 16);
      if (c % 17 == 16) wr(3'd5, N'(c % 16), "R4");
      else run("R9");
    end
    db_tick = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule